// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block computes the effective memory address of a memory operand for a two-operand instruction set. The decode stage supplies an addressing mode and the values already read from the register file: a base, an index, a two-bit scale code and a displacement that has already been sign-extended. The block returns the address after one clock. All arithmetic wraps modulo 2^ADDR_W, and there is no overflow indication.

The block also checks the operand pair of the instruction. The destination and the source each carry a kind code. If the pair is not an allowed combination, the result arrives with an error flag, the address is forced to zero, and the instruction is reported as illegal.

Top module: `scaled_index_agu`

## Requirements
- R1: With mode code 0 (register indirect), the address equals the base value.
- R2: With mode code 1, the address equals base + displacement.
- R3: With mode code 2, the address equals base + (index shifted left by the scale code).
- R4: With mode code 3, the address equals base + (index shifted left by the scale code) + displacement.
- R5: Scale codes 0, 1, 2 and 3 multiply the index by 1, 2, 4 and 8.
- R6: The address wraps modulo 2^32, so any carry out of bit 31 is dropped.
- R7: Operand kind codes are 0 = register, 1 = immediate, 2 = memory and 3 = reserved, written as (destination, source). The legal pairs are (0,0), (0,1), (0,2), (2,0) and (2,1). Any other pair, including memory-memory, gives out_err = 1 with out_addr = 0.
- R8: out_valid equals in_valid from the previous clock. Whenever out_valid is 0, both out_addr and out_err are 0.
- R9: While rst_n is low, out_valid, out_err and out_addr are 0.
- R10: Inputs that the selected mode does not use (the index and scale in modes 0 and 1, the displacement in modes 0 and 2) do not change the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| in_mode | input | 2 | Addressing mode code |
| in_base | input | 32 | Base register value |
| in_index | input | 32 | Index register value |
| in_scale | input | 2 | Index shift amount (0..3) |
| in_disp | input | 32 | Sign-extended displacement |
| in_dst_kind | input | 2 | Destination operand kind |
| in_src_kind | input | 2 | Source operand kind |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_addr | output | 32 | Effective address, 0 when invalid or illegal |
| out_err | output | 1 | Illegal operand pair |

## Verification
The block holds only one register stage, so any fault in the term selection, the scaler or the adder shows up on out_addr on the very next clock after the request. A wrong legality decision appears at the same time, as out_err set or missing and as a non-zero address where zero is required. A stuck valid or error register appears on the first idle cycle, when out_addr and out_err fail to return to zero. The reference model compares all three outputs on every cycle, so each of these faults is reported in the cycle where it first appears.

// File: rtl/agu_pkg.sv
package agu_pkg;

   typedef enum logic [1:0] {
      AM_REG_IND       = 2'd0,
      AM_BASE_DISP     = 2'd1,
      AM_BASE_IDX      = 2'd2,
      AM_BASE_IDX_DISP = 2'd3
   } agu_mode_e;

   typedef enum logic [1:0] {
      OPK_REG  = 2'd0,
      OPK_IMM  = 2'd1,
      OPK_MEM  = 2'd2,
      OPK_RSVD = 2'd3
   } opnd_kind_e;

   typedef struct packed {
      logic use_index;
      logic use_disp;
   } term_sel_t;

endpackage

// File: rtl/agu_term_select.sv
module agu_term_select
   import agu_pkg::*;
(
   input  logic [1:0] mode,
   output term_sel_t  sel
);
   agu_mode_e mode_e;
   assign mode_e = agu_mode_e'(mode);

   always_comb begin
      sel = '0;
      unique case (mode_e)
         AM_REG_IND:       sel = '{use_index: 1'b0, use_disp: 1'b0};
         AM_BASE_DISP:     sel = '{use_index: 1'b0, use_disp: 1'b1};
         AM_BASE_IDX:      sel = '{use_index: 1'b1, use_disp: 1'b0};
         AM_BASE_IDX_DISP: sel = '{use_index: 1'b1, use_disp: 1'b1};
         default:          sel = '0;
      endcase
   end
endmodule

// File: rtl/agu_pair_check.sv
module agu_pair_check
   import agu_pkg::*;
(
   input  logic [1:0] dst_kind,
   input  logic [1:0] src_kind,
   output logic       legal
);
   opnd_kind_e dk, sk;
   assign dk = opnd_kind_e'(dst_kind);
   assign sk = opnd_kind_e'(src_kind);

   always_comb begin
      legal = 1'b0;
      unique case (dk)
         OPK_REG: legal = (sk == OPK_REG) || (sk == OPK_IMM) || (sk == OPK_MEM);
         OPK_MEM: legal = (sk == OPK_REG) || (sk == OPK_IMM);
         default: legal = 1'b0;
      endcase
   end
endmodule

// File: rtl/agu_scaler.sv
module agu_scaler #(
   parameter int ADDR_W      = 32,
   parameter int SCALE_W     = 2,
   parameter int SHIFT_STYLE = 0
) (
   input  logic [ADDR_W-1:0]  idx,
   input  logic [SCALE_W-1:0] sh,
   output logic [ADDR_W-1:0]  scaled
);
   generate
      if (SHIFT_STYLE == 0) begin : g_barrel
         logic [ADDR_W-1:0] stage [SCALE_W+1];
         assign stage[0] = idx;
         for (genvar i = 0; i < SCALE_W; i++) begin : g_stage
            localparam int STEP = 1 << i;
            assign stage[i+1] = sh[i] ? {stage[i][ADDR_W-1-STEP:0], {STEP{1'b0}}}
                                      : stage[i];
         end
         assign scaled = stage[SCALE_W];
      end else begin : g_mult
         logic [ADDR_W-1:0] factor;
         assign factor = {{(ADDR_W-1){1'b0}}, 1'b1} << sh;
         assign scaled = idx * factor;
      end
   endgenerate
endmodule

// File: rtl/agu_adder3.sv
module agu_adder3 #(
   parameter int ADDR_W    = 32,
   parameter int ADD_STYLE = 1
) (
   input  logic [ADDR_W-1:0] a,
   input  logic [ADDR_W-1:0] b,
   input  logic [ADDR_W-1:0] c,
   output logic [ADDR_W-1:0] sum
);
   generate
      if (ADD_STYLE == 0) begin : g_plain
         assign sum = a + b + c;
      end else begin : g_csa
         logic [ADDR_W-1:0] s_vec, c_vec, c_shift;
         assign s_vec   = a ^ b ^ c;
         assign c_vec   = (a & b) | (a & c) | (b & c);
         assign c_shift = {c_vec[ADDR_W-2:0], 1'b0};
         assign sum     = s_vec + c_shift;
      end
   endgenerate
endmodule

// File: rtl/scaled_index_agu.sv
module scaled_index_agu
   import agu_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int SCALE_W     = 2,
   parameter int SHIFT_STYLE = 0,
   parameter int ADD_STYLE   = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               in_valid,
   input  logic [1:0]         in_mode,
   input  logic [ADDR_W-1:0]  in_base,
   input  logic [ADDR_W-1:0]  in_index,
   input  logic [SCALE_W-1:0] in_scale,
   input  logic [ADDR_W-1:0]  in_disp,
   input  logic [1:0]         in_dst_kind,
   input  logic [1:0]         in_src_kind,
   output logic               out_valid,
   output logic [ADDR_W-1:0]  out_addr,
   output logic               out_err
);
   localparam int MAX_SHIFT = (1 << SCALE_W) - 1;

   generate
      if (ADDR_W < 8) begin : g_bad_width
         $error("scaled_index_agu: ADDR_W must be at least 8");
      end
      if (SCALE_W < 1 || MAX_SHIFT >= ADDR_W) begin : g_bad_scale
         $error("scaled_index_agu: SCALE_W out of range for ADDR_W");
      end
      if (SHIFT_STYLE < 0 || SHIFT_STYLE > 1) begin : g_bad_shift
         $error("scaled_index_agu: SHIFT_STYLE must be 0 or 1");
      end
      if (ADD_STYLE < 0 || ADD_STYLE > 1) begin : g_bad_add
         $error("scaled_index_agu: ADD_STYLE must be 0 or 1");
      end
   endgenerate

   term_sel_t         sel;
   logic              pair_ok;
   logic [ADDR_W-1:0] idx_scaled, idx_term, disp_term, ea_next;

   agu_term_select u_sel (
      .mode (in_mode),
      .sel  (sel)
   );

   agu_pair_check u_pair (
      .dst_kind (in_dst_kind),
      .src_kind (in_src_kind),
      .legal    (pair_ok)
   );

   agu_scaler #(
      .ADDR_W      (ADDR_W),
      .SCALE_W     (SCALE_W),
      .SHIFT_STYLE (SHIFT_STYLE)
   ) u_scale (
      .idx    (in_index),
      .sh     (in_scale),
      .scaled (idx_scaled)
   );

   assign idx_term  = sel.use_index ? idx_scaled : '0;
   assign disp_term = sel.use_disp  ? in_disp    : '0;

   agu_adder3 #(
      .ADDR_W    (ADDR_W),
      .ADD_STYLE (ADD_STYLE)
   ) u_add (
      .a   (in_base),
      .b   (idx_term),
      .c   (disp_term),
      .sum (ea_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_err   <= 1'b0;
         out_addr  <= '0;
      end else begin
         out_valid <= in_valid;
         out_err   <= in_valid & ~pair_ok;
         out_addr  <= (in_valid && pair_ok) ? ea_next : '0;
      end
   end
endmodule

// File: rtl/scaled_index_agu_chk.sv
module scaled_index_agu_chk #(
   parameter int ADDR_W  = 32,
   parameter int SCALE_W = 2
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic [1:0]         in_mode,
   input logic [ADDR_W-1:0]  in_base,
   input logic [ADDR_W-1:0]  in_index,
   input logic [SCALE_W-1:0] in_scale,
   input logic [ADDR_W-1:0]  in_disp,
   input logic [1:0]         in_dst_kind,
   input logic [1:0]         in_src_kind,
   input logic               out_valid,
   input logic [ADDR_W-1:0]  out_addr,
   input logic               out_err
);
   logic rr_pair;
   assign rr_pair = (in_dst_kind == 2'd0) && (in_src_kind == 2'd0);

   assert_mode0_base_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd0 && rr_pair) |=> (out_addr == $past(in_base) && !out_err));

   assert_mode2_unit_scale_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_mode == 2'd2 && in_scale == '0 && rr_pair)
         |=> (out_addr == $past(in_base) + $past(in_index)));

   assert_memmem_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_dst_kind == 2'd2 && in_src_kind == 2'd2) |=> (out_err && out_addr == '0));

   assert_err_zero_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_err |-> (out_valid && out_addr == '0));

   assert_latency_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == $past(in_valid));

   assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (!out_err && out_addr == '0));

   assert_reset_clear_R9: assert property (@(posedge clk)
      $past(!rst_n) |-> (!out_valid && !out_err && out_addr == '0));
endmodule

bind scaled_index_agu scaled_index_agu_chk #(
   .ADDR_W  (ADDR_W),
   .SCALE_W (SCALE_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_mode     (in_mode),
   .in_base     (in_base),
   .in_index    (in_index),
   .in_scale    (in_scale),
   .in_disp     (in_disp),
   .in_dst_kind (in_dst_kind),
   .in_src_kind (in_src_kind),
   .out_valid   (out_valid),
   .out_addr    (out_addr),
   .out_err     (out_err)
);

// File: tb/scaled_index_agu_bench.sv
module scaled_index_agu_bench;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        in_valid;
   logic [1:0]  in_mode;
   logic [31:0] in_base, in_index, in_disp;
   logic [1:0]  in_scale, in_dst_kind, in_src_kind;
   logic        out_valid, out_err;
   logic [31:0] out_addr;

   int compared   = 0;
   int mismatched = 0;
   bit finished   = 1'b0;

   logic        exp_valid, exp_err;
   logic [31:0] exp_addr;
   string       exp_tag;

   always #(CLK_PERIOD/2) clk = ~clk;

   scaled_index_agu u_scaled_index_agu (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
      .in_base(in_base), .in_index(in_index), .in_scale(in_scale),
      .in_disp(in_disp), .in_dst_kind(in_dst_kind), .in_src_kind(in_src_kind),
      .out_valid(out_valid), .out_addr(out_addr), .out_err(out_err)
   );

   function automatic bit ref_legal(input logic [1:0] d, input logic [1:0] s);
      if (d == 2'd0) return (s != 2'd3);
      if (d == 2'd2) return (s == 2'd0 || s == 2'd1);
      return 1'b0;
   endfunction

   function automatic logic [31:0] ref_addr(input logic [1:0] m, input logic [31:0] b,
                                            input logic [31:0] x, input logic [1:0] sc,
                                            input logic [31:0] d);
      longint unsigned acc;
      longint unsigned mul;
      mul = 1;
      for (int k = 0; k < int'(sc); k++) mul = mul * 2;
      acc = longint'(b);
      if (m == 2'd2 || m == 2'd3) acc = acc + longint'(x) * mul;
      if (m == 2'd1 || m == 2'd3) acc = acc + longint'(d);
      return acc[31:0];
   endfunction

   task automatic cmp1(input string what, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s: actual %h expected %h", exp_tag, what, act, exp);
      end
   endtask

   task automatic compare_now();
      cmp1("out_valid", {31'b0, out_valid}, {31'b0, exp_valid});
      cmp1("out_err",   {31'b0, out_err},   {31'b0, exp_err});
      cmp1("out_addr",  out_addr,           exp_addr);
   endtask

   // one request per call; outputs of the previous request are compared first
   task automatic step(input string tag, input logic v, input logic [1:0] m,
                       input logic [31:0] b, input logic [31:0] x, input logic [1:0] sc,
                       input logic [31:0] d, input logic [1:0] dk, input logic [1:0] sk);
      @(negedge clk);
      compare_now();
      in_valid = v; in_mode = m; in_base = b; in_index = x;
      in_scale = sc; in_disp = d; in_dst_kind = dk; in_src_kind = sk;
      exp_tag   = tag;
      exp_valid = v;
      exp_err   = v && !ref_legal(dk, sk);
      exp_addr  = (v && ref_legal(dk, sk)) ? ref_addr(m, b, x, sc, d) : 32'h0;
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      in_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      exp_tag = "R9"; exp_valid = 0; exp_err = 0; exp_addr = 0;
      compare_now();
      rst_n = 1'b1;
   endtask

   initial begin
      in_valid = 0; in_mode = 0; in_base = 0; in_index = 0; in_scale = 0;
      in_disp = 0; in_dst_kind = 0; in_src_kind = 0;
      do_reset();
      exp_tag = "R8"; exp_valid = 0; exp_err = 0; exp_addr = 0;

      step("R1",  1, 2'd0, 32'h1234_5678, 32'hdead_beef, 2'd3, 32'h0000_0100, 2'd0, 2'd0);
      step("R10", 1, 2'd0, 32'h0000_4000, 32'hffff_ffff, 2'd2, 32'h7fff_0000, 2'd0, 2'd2);
      step("R2",  1, 2'd1, 32'h0001_0000, 32'h5555_5555, 2'd3, 32'hffff_fff0, 2'd2, 2'd0);
      step("R10", 1, 2'd1, 32'h0001_0000, 32'h0000_0001, 2'd0, 32'hffff_fff0, 2'd0, 2'd1);
      for (int s = 0; s < 4; s++)
         step("R5", 1, 2'd2, 32'h0008_0000, 32'h0000_0013, s[1:0], 32'h1111_1111, 2'd0, 2'd0);
      step("R3",  1, 2'd2, 32'h1000_0000, 32'h8000_0001, 2'd1, 32'h0, 2'd2, 2'd1);
      step("R4",  1, 2'd3, 32'h0000_8000, 32'h0000_0005, 2'd2, 32'h0000_0024, 2'd0, 2'd2);
      step("R4",  1, 2'd3, 32'h0010_0000, 32'h0000_0100, 2'd3, 32'hffff_fffc, 2'd2, 2'd0);
      step("R6",  1, 2'd1, 32'hffff_fff0, 32'h0, 2'd0, 32'h0000_0020, 2'd0, 2'd0);
      step("R6",  1, 2'd3, 32'hffff_ff00, 32'h4000_0000, 2'd3, 32'h0000_0200, 2'd0, 2'd0);
      step("R7",  1, 2'd1, 32'h0000_1000, 32'h0, 2'd0, 32'h4, 2'd2, 2'd2);
      step("R7",  1, 2'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h4, 2'd1, 2'd0);
      step("R7",  1, 2'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h4, 2'd0, 2'd3);
      step("R7",  1, 2'd0, 32'h0000_1000, 32'h0, 2'd0, 32'h4, 2'd3, 2'd1);
      step("R7",  1, 2'd0, 32'h0000_2000, 32'h0, 2'd0, 32'h4, 2'd2, 2'd1);
      step("R8",  0, 2'd3, 32'habcd_0000, 32'h7, 2'd1, 32'h9, 2'd2, 2'd2);
      step("R8",  0, 2'd1, 32'h1, 32'h1, 2'd1, 32'h1, 2'd0, 2'd0);
      step("R8",  1, 2'd2, 32'h0000_0040, 32'h0000_0002, 2'd2, 32'h0, 2'd0, 2'd1);
      for (int k = 0; k < 40; k++)
         step("R4", 1, k[1:0], 32'h0100_0000 + 32'(k * 4099), 32'(k * 977),
              k[3:2], 32'hffff_f000 + 32'(k * 131), 2'(k % 4), 2'((k / 4) % 4));
      step("R8",  1, 2'd3, 32'h0000_0010, 32'h0000_0001, 2'd3, 32'h1, 2'd0, 2'd0);
      do_reset();
      exp_tag = "R8"; exp_valid = 0; exp_err = 0; exp_addr = 0;
      step("R1",  1, 2'd0, 32'hcafe_0000, 32'h0, 2'd0, 32'h0, 2'd2, 2'd0);
      step("R8",  0, 2'd0, 32'h0, 32'h0, 2'd0, 32'h0, 2'd0, 2'd0);
      @(negedge clk);
      compare_now();
      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: actual hung expected done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end
endmodule